// File: doc/BRIEF.md
# Stepper Phase Head Position Tracker

This block follows the head of a five-and-a-quarter-inch floppy mechanism by watching the four stepper magnet enables that a disk controller drives. It keeps a half-track position index and updates it by one whenever the magnet next to the current one takes over. From that index it reports the whole track number and a flag that shows whether the head rests on an odd, in-between position. A drive emulator uses these outputs to pick which recorded bit stream to play back.

The magnet inputs are asynchronous levels. They pass through a two-flop synchronizer before they are decoded. Direction comes only from which neighbouring magnet becomes active. A higher-numbered neighbour, taken cyclically, moves the head inward. A lower-numbered neighbour moves it outward. The block has no data stream, so every pin is a plain level or strobe. Motor timing and the host's step delays are not modelled.

Top module: `head_phase_tracker`

## Requirements
- R1: After reset, the position, track and half-track flag are all 0 and the moved strobe is low.
- R2: Bit i of `phase_en` drives magnet i. The magnet that belongs to position p is p mod 4. The position rises by one when the magnet at (p+1) mod 4 is on and the magnets at p and (p+3) mod 4 are off. Walking the magnets in ascending cyclic order therefore steps the head inward.
- R3: The position falls by one when the magnet at (p+3) mod 4 is on and the magnets at p and (p+1) mod 4 are off. Walking the magnets in descending order therefore steps the head toward position 0.
- R4: The position does not change while the magnet of the current position is still on, even if a neighbour is also on. The update happens only once the previous magnet has been released.
- R5: `track_num` is the position divided by two (range 0 to 34), and `half_track` is the lowest bit of the position.
- R6: The position stays within 0 to 69. A step request outward at 0 or inward at 69 leaves the position unchanged and raises no strobe.
- R7: If no magnet is on, or only the magnet opposite the current one ((p+2) mod 4) is on, the position does not change.
- R8: Each change of the position raises `moved` for exactly one clock cycle. The change and the strobe appear on the third rising edge after the magnet inputs change: two edges for the synchronizer and one for the position register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_en | input | 4 | Asynchronous magnet enables, bit i = magnet i |
| phase_pos | output | 7 | Half-track position, 0 to 69 |
| track_num | output | 6 | Whole track, position divided by two |
| half_track | output | 1 | High on odd positions |
| moved | output | 1 | One-cycle pulse on every position change |

## Verification
The bench walks the head across the full range one magnet at a time and checks the position, track, half-track flag and strobe at each step. It then pushes against both ends. A tracker without clamping would wrap to 0 or 69, or raise a false strobe. An overlap pattern with the old and new magnets both on is applied before the release. A decoder that moves as soon as the neighbour turns on would step early, or would bounce back toward the still-energized magnet. Energizing nothing, or only the opposite magnet, must leave the head still, because a decoder that treats the opposite magnet as a neighbour would jump. Every check samples exactly three edges after the input change, so a missing or extra synchronizer stage shows up as a wrong strobe cycle.

// File: rtl/head_trk_pkg.sv
package head_trk_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_IN   = 2'd1,
    STEP_OUT  = 2'd2
  } step_e;
endpackage

// File: rtl/phase_sync.sv
module phase_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/step_decoder.sv
module step_decoder
  import head_trk_pkg::*;
#(
  parameter int NUM_PH = 4,
  localparam int PH_W  = $clog2(NUM_PH)
) (
  input  logic [NUM_PH-1:0] magnets,
  input  logic [PH_W-1:0]   cur_idx,
  output step_e             step
);
  logic [PH_W-1:0] idx_in;
  logic [PH_W-1:0] idx_out;
  logic            cur_on, in_on, out_on;

  always_comb begin
    idx_in  = cur_idx + PH_W'(1);
    idx_out = cur_idx - PH_W'(1);
    cur_on  = magnets[cur_idx];
    in_on   = magnets[idx_in];
    out_on  = magnets[idx_out];
    step    = STEP_HOLD;
    if (!cur_on) begin
      if (in_on && !out_on)      step = STEP_IN;
      else if (out_on && !in_on) step = STEP_OUT;
    end
  end
endmodule

// File: rtl/position_counter.sv
module position_counter
  import head_trk_pkg::*;
#(
  parameter int NUM_POS = 70,
  localparam int POS_W  = $clog2(NUM_POS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  output logic [POS_W-1:0] pos,
  output logic             moved
);
  localparam logic [POS_W-1:0] TOP = POS_W'(NUM_POS - 1);

  logic can_in, can_out;

  always_comb begin
    can_in  = (step == STEP_IN)  && (pos != TOP);
    can_out = (step == STEP_OUT) && (pos != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      moved <= 1'b0;
    end else begin
      moved <= can_in || can_out;
      if (can_in)       pos <= pos + POS_W'(1);
      else if (can_out) pos <= pos - POS_W'(1);
    end
  end
endmodule

// File: rtl/head_phase_tracker.sv
module head_phase_tracker
  import head_trk_pkg::*;
#(
  parameter int NUM_POS    = 70,
  parameter int NUM_PH     = 4,
  parameter int SYNC_DEPTH = 2,
  localparam int POS_W     = $clog2(NUM_POS),
  localparam int TRK_W     = POS_W - 1,
  localparam int PH_W      = $clog2(NUM_PH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PH-1:0] phase_en,
  output logic [POS_W-1:0]  phase_pos,
  output logic [TRK_W-1:0]  track_num,
  output logic              half_track,
  output logic              moved
);
  logic [NUM_PH-1:0] magnets_s;
  step_e             step;

  phase_sync #(.WIDTH(NUM_PH), .STAGES(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (phase_en),
    .sync_out (magnets_s)
  );

  step_decoder #(.NUM_PH(NUM_PH)) u_dec (
    .magnets (magnets_s),
    .cur_idx (phase_pos[PH_W-1:0]),
    .step    (step)
  );

  position_counter #(.NUM_POS(NUM_POS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .pos   (phase_pos),
    .moved (moved)
  );

  assign track_num  = phase_pos[POS_W-1:1];
  assign half_track = phase_pos[0];
endmodule

// File: rtl/head_phase_tracker_chk.sv
module head_phase_tracker_chk #(
  parameter int NUM_POS = 70,
  parameter int NUM_PH  = 4,
  localparam int POS_W  = $clog2(NUM_POS),
  localparam int TRK_W  = POS_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_PH-1:0] phase_en,
  input logic [POS_W-1:0]  phase_pos,
  input logic [TRK_W-1:0]  track_num,
  input logic              half_track,
  input logic              moved
);
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_pos < POS_W'(NUM_POS));

  p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0 && phase_pos != $past(phase_pos)) |->
      (phase_pos == $past(phase_pos) + POS_W'(1) ||
       phase_pos == $past(phase_pos) - POS_W'(1)));

  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0) |-> (moved == (phase_pos != $past(phase_pos))));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && $past(phase_en, 3) == '0) |-> !moved);

  p_track_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 0 && !moved) |-> ($stable(track_num) && $stable(half_track)));
endmodule

bind head_phase_tracker head_phase_tracker_chk #(.NUM_POS(NUM_POS), .NUM_PH(NUM_PH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase_en   (phase_en),
  .phase_pos  (phase_pos),
  .track_num  (track_num),
  .half_track (half_track),
  .moved      (moved)
);

// File: tb/head_phase_tracker_bench.sv
`timescale 1ns/1ps
module head_phase_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] phase_en = 4'b0;
  logic [6:0] phase_pos;
  logic [5:0] track_num;
  logic       half_track;
  logic       moved;

  int checks = 0;
  int failures = 0;
  int exp_pos = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  head_phase_tracker u_head_phase_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_en   (phase_en),
    .phase_pos  (phase_pos),
    .track_num  (track_num),
    .half_track (half_track),
    .moved      (moved)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input int exp_moved);
    check(req, "pos", int'(phase_pos), exp_pos);
    check("R5", "track", int'(track_num), exp_pos / 2);
    check("R5", "half", int'(half_track), exp_pos % 2);
    check(req, "moved", int'(moved), exp_moved);
  endtask

  // Drive a pattern, wait the three-edge latency, check, then check the strobe dropped.
  task automatic apply(input logic [3:0] pat, input int delta, input string req);
    @(negedge clk);
    phase_en = pat;
    repeat (3) @(posedge clk);
    #1;
    exp_pos = exp_pos + delta;
    check_state(req, (delta != 0) ? 1 : 0);
    @(posedge clk);
    #1;
    check("R8", "strobe one cycle", int'(moved), 0);
  endtask

  function automatic logic [3:0] onehot(input int idx);
    return 4'b0001 << (idx % 4);
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    phase_en = 4'b0;
    repeat (3) @(posedge clk);
    #1;
    exp_pos = 0;
    check_state("R1", 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_overlap();
    apply(4'b0001, 0, "R4");
    apply(4'b0011, 0, "R4");
    apply(4'b0010, 1, "R2");
    apply(4'b0011, 0, "R4");
    apply(4'b0001, -1, "R3");
  endtask

  task automatic t_idle_opposite();
    apply(4'b0000, 0, "R7");
    apply(onehot(exp_pos + 2), 0, "R7");
    apply(4'b0000, 0, "R7");
  endtask

  task automatic t_walk_in();
    for (int i = 0; i < 69; i++) apply(onehot(exp_pos + 1), 1, "R2");
    check("R6", "reached top", exp_pos, 69);
  endtask

  task automatic t_clamp_top();
    apply(onehot(exp_pos + 1), 0, "R6");
  endtask

  task automatic t_walk_out();
    for (int i = 0; i < 69; i++) apply(onehot(exp_pos + 3), -1, "R3");
  endtask

  task automatic t_clamp_bottom();
    apply(onehot(exp_pos + 3), 0, "R6");
    apply(onehot(exp_pos), 0, "R6");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_overlap();
    t_idle_opposite();
    t_walk_in();
    t_idle_opposite();
    t_clamp_top();
    t_walk_out();
    t_clamp_bottom();
    t_idle_opposite();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule